// File: doc/BRIEF.md
# Stack Segment Bounds Checker

This block decides whether a stack push or pop may go ahead. The decision uses the cached descriptor of the current stack segment, the stack pointer and the number of bytes to be moved. The cached descriptor supplies the attribute bits, the segment limit and the segment end. The caller raises a one-cycle request strobe with a push/pop select. One clock later the block presents a registered stack-fault flag and a 16-bit error code. Both hold until the next request.

When the protection checks are switched off, every request passes. When they are on, the block first looks at the descriptor attributes. It then applies one of four range rules, chosen by the direction (push or pop) and by whether the segment grows down or up. The default-size bit sets the upper bound of the pointer range, which is 16-bit or full width. All range arithmetic is done two bits wider than the pointer, so an underflow shows up as a negative value and cannot wrap into a false pass. Every fault is reported with the same error code: the selector with its two low bits cleared.

Top module: `stack_bound_chk`

## Requirements
- R1: After a synchronous reset, `fault` is 0 and `err_code` is 0.
- R2: With `prot_en` low, a request always yields `fault`=0, whatever the descriptor and pointer.
- R3: With `prot_en` high, a request faults if `dsc_valid` is 0 or `dsc_present` is 0.
- R4: With `prot_en` high, a request faults if any of these holds: `dsc_is_mem` is 0 (system descriptor), `dsc_code` is 1, or `dsc_write` is 0.
- R5: For an expand-down push (`dsc_down`=1, `is_pop`=0), the request faults when any of these holds: `sp` is 0, `sp` < `acc_len`, `sp - acc_len` <= `seg_limit`, or `sp` > the upper bound.
- R6: For an expand-up push with `sp`=0, the request faults unless `seg_end` equals the upper bound.
- R7: For an expand-up push with `sp`!=0, the request faults if `sp` < `acc_len` or if `sp - 1` > `seg_limit`.
- R8: For an expand-down pop, the request faults if `sp` equals the upper bound, or if (upper bound − `sp`) + 1 < `acc_len`, evaluated as a signed difference.
- R9: For an expand-up pop, the request faults when any of these holds: `sp` equals the upper bound, `seg_end` is 0, `sp` > `seg_limit`, or (`seg_limit` − `sp`) + 1 < `acc_len`.
- R10: The upper bound is 0x0000FFFF when `dsc_big` is 0 and 0xFFFFFFFF when `dsc_big` is 1.
- R11: On a faulting request, `err_code` is `sel` with bits 1:0 forced to 0. On a passing request, `err_code` is 0.
- R12: `fault` and `err_code` update on the clock edge where `req` is sampled high. They keep their values on every edge where `req` is low, even if other inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Check request strobe |
| is_pop | input | 1 | 1 = pop, 0 = push |
| prot_en | input | 1 | Protection checks enabled |
| sel | input | 16 | Stack segment selector |
| dsc_valid | input | 1 | Descriptor cache entry valid |
| dsc_present | input | 1 | Segment present |
| dsc_is_mem | input | 1 | 1 = code/data descriptor, 0 = system descriptor |
| dsc_code | input | 1 | 1 = code segment |
| dsc_write | input | 1 | Data segment writable |
| dsc_down | input | 1 | Segment grows down |
| dsc_big | input | 1 | 32-bit default size |
| seg_limit | input | 32 | Segment limit |
| seg_end | input | 32 | Segment end address |
| sp | input | 32 | Stack pointer |
| acc_len | input | 4 | Access length in bytes, 1 to 10 |
| fault | output | 1 | Registered stack-fault flag |
| err_code | output | 16 | Registered error code |

## Verification
The output register is the only state, so most internal errors appear on the first edge after a request. A wrong rule selection, bound or comparison shows as a wrong `fault` on that edge. A bad error-code mask shows as wrong low bits of `err_code`. A register that reloads while the strobe is low shows one edge after the inputs change with no request. The directed corners sit exactly on each comparison boundary, one byte inside and one byte outside. This means an off-by-one or a narrowed subtraction flips a check on the first request that crosses it.

// File: rtl/stk_chk_pkg.sv
package stk_chk_pkg;
  typedef struct packed {
    logic valid;
    logic present;
    logic is_mem;
    logic code;
    logic write;
    logic down;
    logic big;
  } stk_attr_t;

  typedef enum logic [1:0] {
    RULE_PUSH_UP   = 2'b00,
    RULE_PUSH_DOWN = 2'b01,
    RULE_POP_UP    = 2'b10,
    RULE_POP_DOWN  = 2'b11
  } stk_rule_e;
endpackage

// File: rtl/stk_attr_chk.sv
module stk_attr_chk
  import stk_chk_pkg::*;
(
  input  stk_attr_t attr,
  output logic      attr_bad
);
  logic missing;
  logic wrong_kind;

  always_comb begin
    missing    = !attr.valid || !attr.present;
    wrong_kind = !attr.is_mem || attr.code || !attr.write;
    attr_bad   = missing || wrong_kind;
  end
endmodule

// File: rtl/stk_range_chk.sv
module stk_range_chk
  import stk_chk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int LEN_W    = 4
) (
  input  logic              down,
  input  logic              big,
  input  logic              is_pop,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [ADDR_W-1:0] seg_end,
  input  logic [ADDR_W-1:0] sp,
  input  logic [LEN_W-1:0]  acc_len,
  output logic              range_bad
);
  localparam int XW = ADDR_W + 2;
  localparam logic [ADDR_W-1:0] NARROW_TOP = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [ADDR_W-1:0] WIDE_TOP   = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] top;
  logic signed [XW-1:0] sp_x, lim_x, top_x, len_x, one_x;
  logic signed [XW-1:0] sp_less_len, top_room, lim_room;
  logic sp_zero, sp_at_top;
  stk_rule_e rule;
  logic bad_push_dn, bad_push_up, bad_pop_dn, bad_pop_up;

  always_comb begin
    top   = big ? WIDE_TOP : NARROW_TOP;
    sp_x  = $signed({2'b00, sp});
    lim_x = $signed({2'b00, seg_limit});
    top_x = $signed({2'b00, top});
    len_x = $signed({{(XW-LEN_W){1'b0}}, acc_len});
    one_x = $signed({{(XW-1){1'b0}}, 1'b1});

    sp_less_len = sp_x - len_x;
    top_room    = top_x - sp_x + one_x;
    lim_room    = lim_x - sp_x + one_x;
    sp_zero     = (sp == '0);
    sp_at_top   = (sp == top);
    rule        = stk_rule_e'({is_pop, down});

    bad_push_dn = sp_zero || (sp_x < len_x) || (sp_less_len <= lim_x) || (sp_x > top_x);
    if (sp_zero)
      bad_push_up = (seg_end != top);
    else
      bad_push_up = (sp_x < len_x) || ((sp_x - one_x) > lim_x);
    bad_pop_dn  = sp_at_top || (top_room < len_x);
    bad_pop_up  = sp_at_top || (seg_end == '0) || (sp_x > lim_x) || (lim_room < len_x);

    unique case (rule)
      RULE_PUSH_UP:   range_bad = bad_push_up;
      RULE_PUSH_DOWN: range_bad = bad_push_dn;
      RULE_POP_UP:    range_bad = bad_pop_up;
      default:        range_bad = bad_pop_dn;
    endcase
  end
endmodule

// File: rtl/stack_bound_chk.sv
module stack_bound_chk
  import stk_chk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int LEN_W    = 4,
  parameter int SEL_W    = 16,
  parameter int RPL_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              is_pop,
  input  logic              prot_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic              dsc_valid,
  input  logic              dsc_present,
  input  logic              dsc_is_mem,
  input  logic              dsc_code,
  input  logic              dsc_write,
  input  logic              dsc_down,
  input  logic              dsc_big,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [ADDR_W-1:0] seg_end,
  input  logic [ADDR_W-1:0] sp,
  input  logic [LEN_W-1:0]  acc_len,
  output logic              fault,
  output logic [SEL_W-1:0]  err_code
);
  localparam logic [SEL_W-1:0] SEL_MASK = ~{{(SEL_W-RPL_W){1'b0}}, {RPL_W{1'b1}}};

  stk_attr_t attr;
  logic attr_bad, range_bad, fault_nxt;

  assign attr = '{valid: dsc_valid, present: dsc_present, is_mem: dsc_is_mem,
                  code: dsc_code, write: dsc_write, down: dsc_down, big: dsc_big};

  stk_attr_chk u_attr (
    .attr     (attr),
    .attr_bad (attr_bad)
  );

  stk_range_chk #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W),
    .LEN_W    (LEN_W)
  ) u_range (
    .down      (attr.down),
    .big       (attr.big),
    .is_pop    (is_pop),
    .seg_limit (seg_limit),
    .seg_end   (seg_end),
    .sp        (sp),
    .acc_len   (acc_len),
    .range_bad (range_bad)
  );

  assign fault_nxt = prot_en && (attr_bad || range_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault    <= 1'b0;
      err_code <= '0;
    end else if (req) begin
      fault    <= fault_nxt;
      err_code <= fault_nxt ? (sel & SEL_MASK) : '0;
    end
  end
endmodule

// File: rtl/stack_bound_chk_sva.sv
module stack_bound_chk_sva #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int SEL_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              is_pop,
  input logic              prot_en,
  input logic [SEL_W-1:0]  sel,
  input logic              dsc_valid,
  input logic              dsc_present,
  input logic              dsc_is_mem,
  input logic              dsc_code,
  input logic              dsc_write,
  input logic              dsc_down,
  input logic              dsc_big,
  input logic [ADDR_W-1:0] seg_limit,
  input logic [ADDR_W-1:0] seg_end,
  input logic [ADDR_W-1:0] sp,
  input logic [LEN_W-1:0]  acc_len,
  input logic              fault,
  input logic [SEL_W-1:0]  err_code
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (!fault && err_code == '0));

  assert_prot_off_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (req && !prot_en) |=> !fault);

  assert_missing_desc_R3: assert property (@(posedge clk) disable iff (rst)
    (req && prot_en && (!dsc_valid || !dsc_present)) |=> fault);

  assert_bad_kind_R4: assert property (@(posedge clk) disable iff (rst)
    (req && prot_en && (!dsc_is_mem || dsc_code || !dsc_write)) |=> fault);

  assert_err_low_clear_R11: assert property (@(posedge clk) disable iff (rst)
    err_code[1:0] == 2'b00);

  assert_err_zero_on_pass_R11: assert property (@(posedge clk) disable iff (rst)
    !fault |-> err_code == '0);

  assert_err_tracks_sel_R11: assert property (@(posedge clk) disable iff (rst)
    req |=> (!fault || err_code[SEL_W-1:2] == $past(sel[SEL_W-1:2])));

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(fault) && $stable(err_code)));
endmodule

bind stack_bound_chk stack_bound_chk_sva #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W),
  .SEL_W  (SEL_W)
) u_sva (.*);

// File: tb/stack_bound_chk_tb.sv
module stack_bound_chk_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, is_pop = 1'b0, prot_en = 1'b0;
  logic [15:0] sel = '0;
  logic dsc_valid = 1'b1, dsc_present = 1'b1, dsc_is_mem = 1'b1, dsc_code = 1'b0;
  logic dsc_write = 1'b1, dsc_down = 1'b0, dsc_big = 1'b1;
  logic [31:0] seg_limit = '0, seg_end = '0, sp = '0;
  logic [3:0]  acc_len = 4'd1;
  logic        fault;
  logic [15:0] err_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  stack_bound_chk u_dut (
    .clk(clk), .rst(rst), .req(req), .is_pop(is_pop), .prot_en(prot_en), .sel(sel),
    .dsc_valid(dsc_valid), .dsc_present(dsc_present), .dsc_is_mem(dsc_is_mem),
    .dsc_code(dsc_code), .dsc_write(dsc_write), .dsc_down(dsc_down), .dsc_big(dsc_big),
    .seg_limit(seg_limit), .seg_end(seg_end), .sp(sp), .acc_len(acc_len),
    .fault(fault), .err_code(err_code)
  );

  function automatic bit model_fault();
    longint s, lim, top, len, en;
    bit bad;
    s   = longint'({32'd0, sp});
    lim = longint'({32'd0, seg_limit});
    en  = longint'({32'd0, seg_end});
    len = longint'(acc_len);
    top = dsc_big ? 64'h0000_0000_FFFF_FFFF : 64'h0000_0000_0000_FFFF;
    if (!prot_en) return 1'b0;
    if (!dsc_valid || !dsc_present) return 1'b1;
    if (!dsc_is_mem || dsc_code || !dsc_write) return 1'b1;
    if (!is_pop && dsc_down)
      bad = (s == 0) || (s < len) || (s - len <= lim) || (s > top);
    else if (!is_pop)
      bad = (s == 0) ? (en != top) : ((s < len) || (s - 1 > lim));
    else if (dsc_down)
      bad = (s == top) || ((top - s) + 1 < len);
    else
      bad = (s == top) || (en == 0) || (s > lim) || ((lim - s) + 1 < len);
    return bad;
  endfunction

  task automatic check(input string tag, input logic [15:0] act_e, input bit act_f,
                       input bit exp_f, input logic [15:0] exp_e);
    n_tests++;
    if (act_f !== exp_f || act_e !== exp_e) begin
      n_fail++;
      $display("FAIL %s: fault=%0b err=%h expected fault=%0b err=%h", tag, act_f, act_e, exp_f, exp_e);
    end
  endtask

  // inputs must already be set; pulses req for one edge and checks the result
  task automatic run_req(input string tag);
    bit ef;
    logic [15:0] ee;
    ef = model_fault();
    ee = ef ? (sel & 16'hFFFC) : 16'h0000;
    req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    check(tag, err_code, fault, ef, ee);
  endtask

  task automatic good_desc(input bit down, input bit big);
    prot_en = 1'b1; dsc_valid = 1'b1; dsc_present = 1'b1; dsc_is_mem = 1'b1;
    dsc_code = 1'b0; dsc_write = 1'b1; dsc_down = down; dsc_big = big;
  endtask

  task automatic setr(input bit pop, input logic [31:0] lim, input logic [31:0] en,
                      input logic [31:0] p, input int len);
    is_pop = pop; seg_limit = lim; seg_end = en; sp = p; acc_len = 4'(len);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] held_e;
    bit held_f;
    void'($urandom(32'd20240611));
    sel = 16'hBEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset", err_code, fault, 1'b0, 16'h0000);

    // R2: protection off, broken descriptor still passes
    @(negedge clk);
    prot_en = 1'b0; dsc_valid = 1'b0; dsc_code = 1'b1; setr(1'b0, 32'h10, 32'h0, 32'h0, 4);
    run_req("R2 prot off");

    // R3
    @(negedge clk); good_desc(1'b0, 1'b1); dsc_valid = 1'b0; sel = 16'h1237;
    setr(1'b0, 32'hFFFF, 32'hFFFF, 32'h100, 2);
    run_req("R3 not valid");
    @(negedge clk); good_desc(1'b0, 1'b1); dsc_present = 1'b0; run_req("R3 not present");
    // R4
    @(negedge clk); good_desc(1'b0, 1'b1); dsc_is_mem = 1'b0; run_req("R4 system desc");
    @(negedge clk); good_desc(1'b0, 1'b1); dsc_code = 1'b1; run_req("R4 code seg");
    @(negedge clk); good_desc(1'b0, 1'b1); dsc_write = 1'b0; run_req("R4 read-only");
    @(negedge clk); good_desc(1'b0, 1'b1); sel = 16'h4002; run_req("R11 pass gives zero code");

    // R5 expand-down push
    @(negedge clk); good_desc(1'b1, 1'b1); sel = 16'hFFFF;
    setr(1'b0, 32'h1000, 32'h0, 32'h0, 4);    run_req("R5 zero sp");
    @(negedge clk); setr(1'b0, 32'h0, 32'h0, 32'h2, 4);       run_req("R5 sp below len");
    @(negedge clk); setr(1'b0, 32'h1000, 32'h0, 32'h1004, 4); run_req("R5 lands on limit");
    @(negedge clk); setr(1'b0, 32'h1000, 32'h0, 32'h1005, 4); run_req("R5 just above limit");
    @(negedge clk); good_desc(1'b1, 1'b0);
    setr(1'b0, 32'h100, 32'h0, 32'h10000, 2); run_req("R5 R10 sp over 16-bit bound");
    @(negedge clk); setr(1'b0, 32'h100, 32'h0, 32'hFFFF, 2);  run_req("R5 R10 sp at 16-bit bound");

    // R6 expand-up push with zero pointer
    @(negedge clk); good_desc(1'b0, 1'b1); setr(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 4);
    run_req("R6 R10 wide end ok");
    @(negedge clk); setr(1'b0, 32'hFFFF, 32'hFFFF, 32'h0, 4);  run_req("R6 R10 wide seg narrow end");
    @(negedge clk); good_desc(1'b0, 1'b0); setr(1'b0, 32'hFFFF, 32'hFFFF, 32'h0, 4);
    run_req("R6 R10 narrow end ok");

    // R7 expand-up push nonzero
    @(negedge clk); good_desc(1'b0, 1'b1); setr(1'b0, 32'h2000, 32'h2000, 32'h3, 4);
    run_req("R7 sp below len");
    @(negedge clk); setr(1'b0, 32'h2000, 32'h2000, 32'h2001, 4); run_req("R7 sp-1 at limit");
    @(negedge clk); setr(1'b0, 32'h2000, 32'h2000, 32'h2002, 4); run_req("R7 sp-1 over limit");

    // R8 expand-down pop
    @(negedge clk); good_desc(1'b1, 1'b0); setr(1'b1, 32'h10, 32'h0, 32'hFFFF, 1);
    run_req("R8 sp at bound");
    @(negedge clk); setr(1'b1, 32'h10, 32'h0, 32'hFFFC, 4);  run_req("R8 exact room");
    @(negedge clk); setr(1'b1, 32'h10, 32'h0, 32'hFFFC, 5);  run_req("R8 one short");
    @(negedge clk); setr(1'b1, 32'h10, 32'h0, 32'h12345, 2); run_req("R8 R10 sp past narrow bound");
    @(negedge clk); good_desc(1'b1, 1'b1); setr(1'b1, 32'h10, 32'h0, 32'hFFFFFFFE, 2);
    run_req("R8 wide exact room");
    @(negedge clk); setr(1'b1, 32'h10, 32'h0, 32'hFFFFFFFE, 3); run_req("R8 wide one short");

    // R9 expand-up pop
    @(negedge clk); good_desc(1'b0, 1'b1); setr(1'b1, 32'h3000, 32'h3000, 32'h2FFD, 4);
    run_req("R9 exact room");
    @(negedge clk); setr(1'b1, 32'h3000, 32'h3000, 32'h2FFD, 5);  run_req("R9 one short");
    @(negedge clk); setr(1'b1, 32'h3000, 32'h3000, 32'h3001, 1);  run_req("R9 sp over limit");
    @(negedge clk); setr(1'b1, 32'h3000, 32'h0, 32'h100, 1);      run_req("R9 zero end");
    @(negedge clk); setr(1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1); run_req("R9 sp at bound");

    // R12: a fault result holds while inputs change with no request
    @(negedge clk); good_desc(1'b0, 1'b1); dsc_valid = 1'b0; sel = 16'hA5A6;
    run_req("R12 setup fault");
    held_f = fault; held_e = err_code;
    @(negedge clk); good_desc(1'b0, 1'b1); prot_en = 1'b0; sel = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 hold without req", err_code, fault, held_f, held_e);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] base;
      @(negedge clk);
      prot_en     = ($urandom_range(0, 9) != 0);
      dsc_valid   = ($urandom_range(0, 15) != 0);
      dsc_present = ($urandom_range(0, 15) != 0);
      dsc_is_mem  = ($urandom_range(0, 15) != 0);
      dsc_code    = ($urandom_range(0, 15) == 0);
      dsc_write   = ($urandom_range(0, 15) != 0);
      dsc_down    = 1'($urandom_range(0, 1));
      dsc_big     = 1'($urandom_range(0, 1));
      is_pop      = 1'($urandom_range(0, 1));
      sel         = 16'($urandom);
      acc_len     = 4'($urandom_range(1, 10));
      seg_limit   = dsc_big ? $urandom : 32'($urandom_range(0, 16'hFFFF));
      case ($urandom_range(0, 3))
        0: seg_end = dsc_big ? 32'hFFFFFFFF : 32'h0000FFFF;
        1: seg_end = 32'h0;
        default: seg_end = seg_limit;
      endcase
      case ($urandom_range(0, 4))
        0: base = seg_limit;
        1: base = 32'h0;
        2: base = dsc_big ? 32'hFFFFFFFF : 32'h0000FFFF;
        3: base = 32'($urandom_range(0, 16));
        default: base = $urandom;
      endcase
      sp = base + 32'($urandom_range(0, 22)) - 32'd11;
      run_req(is_pop ? (dsc_down ? "R8 random" : "R9 random")
                     : (dsc_down ? "R5 random" : "R7 random"));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule